// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial bus clock from the system clock in two steps. A prescaler first divides the input clock by (PSC+1) to form a module clock. Two phase counters then set how many module clocks the bus clock spends low and how many it spends high. Each phase also carries a fixed overhead d that depends on the prescaler value. One output period is therefore (PSC+1)·((LOW+d)+(HIGH+d)) input cycles. The module clock is meant to sit between 7 and 12 MHz, and 100 kHz is the usual bus rate target.

Software programs the prescaler, low count and high count through a small register port while the divider is held in reset. It then sets the run bit in the control register. Every period starts with the low phase. A one-cycle falling strobe marks the start of each low phase and a one-cycle rising strobe marks the start of each high phase, so a bus engine can sequence data against the clock edges. The three divider values are copied into working registers at the start of every period.

Top module: `sclk_divider`

## Requirements
- R1: While rst_n is low, scl_o is 1, both strobes are 0 and all four registers read back as 0.
- R2: The low phase lasts (LOW+d)·(PSC+1) input cycles and the high phase lasts (HIGH+d)·(PSC+1) input cycles, so a full period is their sum.
- R3: The overhead d is 7 when PSC is 0, 6 when PSC is 1, and 5 when PSC is 2 or more.
- R4: A write that sets the run bit is taken at clock edge W. At edge W the output stays high. The first low phase begins at edge W+1: scl_o falls there and fall_stb is high for the following cycle.
- R5: fall_stb is high for exactly one input cycle, the first cycle of each low phase. rise_stb is high for exactly one input cycle, the first cycle of each high phase. The two strobes are never high together.
- R6: Bit 5 of the control register is the run bit. While it is 0, scl_o is 1, no strobe is issued and the counters are cleared. Clearing it in mid-period makes scl_o high at the next edge. Setting it again starts a fresh, full low phase.
- R7: A write to the prescaler, low or high register while the run bit is 1 is ignored, and the register reads back its earlier value.
- R8: Register addresses: 0 is the prescaler, 1 the low count, 2 the high count, 3 the control register. rd_data shows the addressed register combinationally, and a write lands at the clock edge where wr_en is high.
- R9: Values written while the divider is held in reset apply from the first period after the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (input) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the addressed register |
| scl_o | output | 1 | Generated serial clock level |
| fall_stb | output | 1 | One-cycle pulse at the start of each low phase |
| rise_stb | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The run bit can be cleared on the same edge where a phase would end and emit a strobe. The bench provokes this by sweeping the clear write across every cycle of a short period. Reset must win in each case: no strobe, scl_o high. A write to a divider register can also fall on a period boundary, where the working copies are being reloaded. Both cases are judged against a behavioural model that counts input cycles and is compared with the outputs on every clock.

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int PSC_W   = 8,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 16,
  parameter int RUN_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              scl_o,
  output logic              fall_stb,
  output logic              rise_stb
);
  localparam int PH_W = CNT_W + 1;

  logic [PSC_W-1:0]  psc_r, sh_psc, pre_cnt;
  logic [CNT_W-1:0]  low_r, high_r, sh_low, sh_high;
  logic [DATA_W-1:0] ctrl_r;
  logic [PH_W-1:0]   ph_cnt, ph_len;
  logic [2:0]        sh_d;
  logic              run, act, in_high, tick, ph_end;

  assign run = ctrl_r[RUN_BIT];

  always_comb begin
    case (addr)
      2'd0:    rd_data = DATA_W'(psc_r);
      2'd1:    rd_data = DATA_W'(low_r);
      2'd2:    rd_data = DATA_W'(high_r);
      default: rd_data = ctrl_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_r  <= '0;
      low_r  <= '0;
      high_r <= '0;
      ctrl_r <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0:    if (!run) psc_r  <= wr_data[PSC_W-1:0];
        2'd1:    if (!run) low_r  <= wr_data[CNT_W-1:0];
        2'd2:    if (!run) high_r <= wr_data[CNT_W-1:0];
        default: ctrl_r <= wr_data;
      endcase
    end
  end

  assign sh_d   = (sh_psc == '0) ? 3'd7 : (sh_psc == PSC_W'(1)) ? 3'd6 : 3'd5;
  assign ph_len = (in_high ? PH_W'(sh_high) : PH_W'(sh_low)) + PH_W'(sh_d);
  assign tick   = (pre_cnt == sh_psc);
  assign ph_end = tick && (ph_cnt == ph_len - PH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      in_high  <= 1'b0;
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      sh_psc   <= '0;
      sh_low   <= '0;
      sh_high  <= '0;
      scl_o    <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else if (!run) begin
      act      <= 1'b0;
      in_high  <= 1'b0;
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      scl_o    <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else if (!act || (ph_end && in_high)) begin
      act      <= 1'b1;
      in_high  <= 1'b0;
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      sh_psc   <= psc_r;
      sh_low   <= low_r;
      sh_high  <= high_r;
      scl_o    <= 1'b0;
      fall_stb <= 1'b1;
      rise_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      pre_cnt  <= tick ? '0 : pre_cnt + PSC_W'(1);
      if (ph_end) begin
        in_high  <= 1'b1;
        ph_cnt   <= '0;
        scl_o    <= 1'b1;
        rise_stb <= 1'b1;
      end else if (tick) begin
        ph_cnt <= ph_cnt + PH_W'(1);
      end
    end
  end
endmodule

module sclk_divider_chk #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [PSC_W-1:0] psc_r,
  input logic [CNT_W-1:0] low_r,
  input logic [CNT_W-1:0] high_r,
  input logic             scl_o,
  input logic             fall_stb,
  input logic             rise_stb
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fall_stb && rise_stb));
  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) fall_stb |-> $fell(scl_o));
  // R5
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) rise_stb |-> $rose(scl_o));
  // R5
  fall_width_chk: assert property (@(posedge clk) disable iff (!rst_n) fall_stb |=> !fall_stb);
  // R5
  rise_width_chk: assert property (@(posedge clk) disable iff (!rst_n) rise_stb |=> !rise_stb);
  // R5
  scl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_o) |-> fall_stb);
  // R6
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (scl_o && !fall_stb && !rise_stb));
  // R7
  locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run && addr != 2'd3) |=> ($stable(psc_r) && $stable(low_r) && $stable(high_r)));
endmodule

bind sclk_divider sclk_divider_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .addr(addr),
  .psc_r(psc_r), .low_r(low_r), .high_r(high_r),
  .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
);

// File: tb/sclk_divider_test.sv
module sclk_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        scl_o, fall_stb, rise_stb;

  int checks = 0;
  int errors = 0;
  bit live = 0;

  sclk_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  always #2 clk = ~clk;

  // behavioural reference: counts input cycles inside a period
  int m_psc, m_low, m_high, m_ctrl, m_t, m_L, m_H;
  bit m_on, m_scl, m_fall, m_rise;

  function automatic int dval(int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic m_start();
    m_t = 0;
    m_L = (m_low + dval(m_psc)) * (m_psc + 1);
    m_H = (m_high + dval(m_psc)) * (m_psc + 1);
    m_scl = 0;
    m_fall = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psc = 0; m_low = 0; m_high = 0; m_ctrl = 0;
      m_on = 0; m_scl = 1; m_fall = 0; m_rise = 0; m_t = 0;
    end else begin
      m_fall = 0;
      m_rise = 0;
      if (((m_ctrl >> 5) & 1) == 0) begin
        m_on = 0;
        m_scl = 1;
      end else if (!m_on) begin
        m_on = 1;
        m_start();
      end else begin
        m_t++;
        if (m_t == m_L) begin
          m_scl = 1;
          m_rise = 1;
        end else if (m_t == m_L + m_H) begin
          m_start();
        end
      end
      if (wr_en) begin
        if (addr == 2'd3) m_ctrl = int'(wr_data);
        else if (((m_ctrl >> 5) & 1) == 0) begin
          if (addr == 2'd0) m_psc = int'(wr_data[7:0]);
          if (addr == 2'd1) m_low = int'(wr_data[7:0]);
          if (addr == 2'd2) m_high = int'(wr_data[7:0]);
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      check("R2", scl_o, m_scl, "scl level vs model");
      check("R5", fall_stb, m_fall, "fall strobe vs model");
      check("R5", rise_stb, m_rise, "rise strobe vs model");
    end
  end

  task automatic wr(int a, int v);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'(a); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk);
    addr = 2'(a);
    @(negedge clk);
    check(tag, int'(rd_data), exp, "register readback");
  endtask

  task automatic measure(int p, int lo, int hi);
    int n, lowlen;
    n = 0; lowlen = -1;
    while (!fall_stb) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
      if (rise_stb) lowlen = n;
    end while (!fall_stb && n < 5000);
    check("R2", lowlen, (lo + dval(p)) * (p + 1), "low phase length");
    check("R3", n, (lo + hi + 2 * dval(p)) * (p + 1), "period length");
  endtask

  task automatic setup(int p, int lo, int hi);
    wr(3, 0);
    wr(0, p); wr(1, lo); wr(2, hi);
    wr(3, 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", scl_o, 1, "scl in reset");
    check("R1", fall_stb | rise_stb, 0, "strobes in reset");
    check("R1", int'(rd_data), 0, "register in reset");
    rst_n = 1'b1;
    live = 1;
    rd_chk("R1", 3, 0);

    // R8 addressing
    wr(0, 2); wr(1, 9); wr(2, 4);
    rd_chk("R8", 0, 2); rd_chk("R8", 1, 9); rd_chk("R8", 2, 4);

    // R4 start latency
    wr(0, 0); wr(1, 3); wr(2, 2);
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wr_data = 16'd32;
    @(negedge clk); wr_en = 1'b0;
    check("R4", scl_o, 1, "scl one cycle after run write");
    @(negedge clk);
    check("R4", fall_stb, 1, "fall strobe two cycles after run write");
    check("R4", scl_o, 0, "scl low two cycles after run write");
    measure(0, 3, 2);                 // R3 d=7

    // R7 writes ignored while running
    wr(0, 5); wr(1, 40); wr(2, 41);
    rd_chk("R7", 0, 0); rd_chk("R7", 1, 3); rd_chk("R7", 2, 2);
    measure(0, 3, 2);

    // R9 new values after reset
    setup(1, 4, 4); measure(1, 4, 4); // R3 d=6
    setup(3, 1, 0); measure(3, 1, 0); // R3 d=5
    setup(2, 0, 0); measure(2, 0, 0); // R3 d=5 minimum counts

    // R6 clear run mid-phase, then restart
    while (!rise_stb) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(3, 0);
    @(negedge clk);
    check("R6", scl_o, 1, "scl after run cleared");
    wr(3, 32);
    measure(2, 0, 0);

    // R6 sweep the clear write over every cycle of a short period
    setup(0, 0, 0);
    for (int k = 0; k < 16; k++) begin
      while (!fall_stb) @(negedge clk);
      repeat (k) @(negedge clk);
      wr(3, 0);
      @(negedge clk);
      check("R6", scl_o, 1, "scl held after clear");
      check("R6", fall_stb | rise_stb, 0, "no strobe after clear");
      wr(3, 32);
    end

    // R7 writes on period boundaries while running
    for (int k = 0; k < 3; k++) begin
      while (!fall_stb) @(negedge clk);
      wr(1, 77);
    end
    rd_chk("R7", 1, 0);
    measure(0, 0, 0);

    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule